// File: doc/BRIEF.md
# Speculative Load Conflict Buffer

This block sits beside the load/store unit of one speculative thread and guards loads that the compiler has hoisted above stores which might alias them. Software issues a mark command carrying the load's address at the hoisted position; the buffer remembers that word address. At the load's original program position software issues an unmark command, which releases the record. While a record is live, every store address of the thread is compared against all remembered addresses at once. A match means the reordering read stale data, so the block raises a sticky conflict flag.

An exception taken while reordered code is in flight also raises the conflict, so that recovery runs non-speculative code. On the cycle the conflict first appears, a one-cycle violate pulse is produced for forwarding to the next thread. Marking the same word twice shares one record with a reference count. A mark that cannot be recorded, because every record is busy or the count is saturated, raises an overflow flag that also counts as a conflict. A thread-restart input wipes every record and every flag.

Top module: `slcb_buffer`

## Requirements
- R1: After reset or restart, all records are free and conflict_o, overflow_o and violate_o are low.
- R2: A store whose word address (address bits above bit 1) equals that of a live record sets conflict_o from the next clock edge; the two low byte-offset bits are not compared.
- R3: A store to a word that no live record holds leaves conflict_o low, and a mark of a word already held reuses that record instead of taking a free one.
- R4: Each mark of a held word adds one to its reference count and each unmark subtracts one; the record stays live until the count reaches zero, and an unmark of a word not held is ignored.
- R5: When mark, unmark and store arrive in the same cycle, the store is compared against the records as they stood before that cycle; a mark or unmark in that cycle only affects later stores, and a record freed by that cycle's unmark cannot be taken by that cycle's mark.
- R6: A mark of a new word while all records are live, or of a held word whose count is at its maximum (2^CNT_W-1), sets overflow_o and conflict_o from the next edge and records nothing.
- R7: An asserted exception input sets conflict_o from the next edge.
- R8: conflict_o and overflow_o stay high until restart_i; restart_i clears every record and flag at the next edge and takes priority over any other input in that cycle.
- R9: violate_o is high for exactly the one cycle in which conflict_o first turns high, and stays low for further causes while conflict_o is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Thread restart: clear all records and flags |
| mark_vld_i | input | 1 | Mark command valid |
| mark_addr_i | input | ADDR_W | Address of the hoisted load |
| unmark_vld_i | input | 1 | Unmark command valid |
| unmark_addr_i | input | ADDR_W | Address of the load being released |
| store_vld_i | input | 1 | Store check valid |
| store_addr_i | input | ADDR_W | Address of the store |
| exc_i | input | 1 | Exception while reordered code is in flight |
| conflict_o | output | 1 | Sticky misspeculation flag |
| overflow_o | output | 1 | Sticky capacity flag |
| violate_o | output | 1 | One-cycle pulse when the conflict first rises |

## Verification
Every result of this block is registered once: a command or store applied before clock edge N shows on conflict_o, overflow_o and violate_o just after edge N, and records changed at edge N are first visible to a store presented in the following cycle. The bench drives each cycle's inputs at the falling edge, queues the outputs that must appear after the next rising edge, and a monitor compares them a quarter period after that rising edge. Same-cycle cases and the reset state are therefore judged against exactly one edge each.

// File: rtl/slcb_pkg.sv
package slcb_pkg;

    typedef struct packed {
        logic conflict;
        logic overflow;
        logic violate;
    } slcb_flags_t;

    localparam int unsigned SLCB_BYTE_BITS = 2;

endpackage

// File: rtl/slcb_match.sv
module slcb_match #(
    parameter int unsigned N    = 8,
    parameter int unsigned WA_W = 30
) (
    input  logic [N-1:0]           vld_i,
    input  logic [N-1:0][WA_W-1:0] waddr_i,
    input  logic [WA_W-1:0]        probe_i,
    output logic [N-1:0]           hit_o
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_o[g] = vld_i[g] && (waddr_i[g] == probe_i);
    end

endmodule

// File: rtl/slcb_alloc.sv
module slcb_alloc #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] vld_i,
    output logic [N-1:0] grant_o,
    output logic         free_o
);

    logic [N:0] taken;

    assign taken[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_pick
        assign grant_o[g]  = !vld_i[g] && !taken[g];
        assign taken[g+1]  = taken[g] || !vld_i[g];
    end

    assign free_o = taken[N];

endmodule

// File: rtl/slcb_buffer.sv
module slcb_buffer
    import slcb_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned CNT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              mark_vld_i,
    input  logic [ADDR_W-1:0] mark_addr_i,
    input  logic              unmark_vld_i,
    input  logic [ADDR_W-1:0] unmark_addr_i,
    input  logic              store_vld_i,
    input  logic [ADDR_W-1:0] store_addr_i,
    input  logic              exc_i,
    output logic              conflict_o,
    output logic              overflow_o,
    output logic              violate_o
);

    localparam int unsigned WA_W = ADDR_W - SLCB_BYTE_BITS;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][WA_W-1:0]  waddr;
        logic [ENTRIES-1:0][CNT_W-1:0] cnt;
        slcb_flags_t                   flags;
    } state_t;

    state_t st_d, st_q;

    logic [WA_W-1:0]    mk_wa, um_wa, sw_wa;
    logic [ENTRIES-1:0] mk_hit, um_hit, sw_hit;
    logic [ENTRIES-1:0] grant;
    logic               free_any;
    logic               set_c, set_o;

    assign mk_wa = mark_addr_i[ADDR_W-1:SLCB_BYTE_BITS];
    assign um_wa = unmark_addr_i[ADDR_W-1:SLCB_BYTE_BITS];
    assign sw_wa = store_addr_i[ADDR_W-1:SLCB_BYTE_BITS];

    slcb_match #(.N(ENTRIES), .WA_W(WA_W)) u_mk_match (
        .vld_i(st_q.vld), .waddr_i(st_q.waddr), .probe_i(mk_wa), .hit_o(mk_hit)
    );

    slcb_match #(.N(ENTRIES), .WA_W(WA_W)) u_um_match (
        .vld_i(st_q.vld), .waddr_i(st_q.waddr), .probe_i(um_wa), .hit_o(um_hit)
    );

    slcb_match #(.N(ENTRIES), .WA_W(WA_W)) u_sw_match (
        .vld_i(st_q.vld), .waddr_i(st_q.waddr), .probe_i(sw_wa), .hit_o(sw_hit)
    );

    slcb_alloc #(.N(ENTRIES)) u_alloc (
        .vld_i(st_q.vld), .grant_o(grant), .free_o(free_any)
    );

    always_comb begin
        st_d  = st_q;
        set_c = 1'b0;
        set_o = 1'b0;
        st_d.flags.violate = 1'b0;

        // Store check and exception use the pre-cycle records.
        if (store_vld_i && (|sw_hit)) set_c = 1'b1;
        if (exc_i) set_c = 1'b1;

        if (unmark_vld_i) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (um_hit[i]) begin
                    if (st_q.cnt[i] == CNT_ONE) begin
                        st_d.vld[i] = 1'b0;
                        st_d.cnt[i] = '0;
                    end else begin
                        st_d.cnt[i] = st_q.cnt[i] - CNT_ONE;
                    end
                end
            end
        end

        if (mark_vld_i) begin
            if (|mk_hit) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (mk_hit[i]) begin
                        if (st_q.cnt[i] == CNT_MAX) begin
                            set_o = 1'b1;
                        end else begin
                            st_d.vld[i] = 1'b1;
                            st_d.cnt[i] = st_d.cnt[i] + CNT_ONE;
                        end
                    end
                end
            end else if (free_any) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (grant[i]) begin
                        st_d.vld[i]   = 1'b1;
                        st_d.waddr[i] = mk_wa;
                        st_d.cnt[i]   = CNT_ONE;
                    end
                end
            end else begin
                set_o = 1'b1;
            end
        end

        if (set_o) set_c = 1'b1;

        st_d.flags.conflict = st_q.flags.conflict | set_c;
        st_d.flags.overflow = st_q.flags.overflow | set_o;
        st_d.flags.violate  = set_c & ~st_q.flags.conflict;

        if (restart_i) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign conflict_o = st_q.flags.conflict;
    assign overflow_o = st_q.flags.overflow;
    assign violate_o  = st_q.flags.violate;

    // R2: a store hitting a live record raises the conflict one edge later
    a_r2_store_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (store_vld_i && (|sw_hit) && !restart_i) |=> conflict_o);

    // R3: one word is never held by two records
    a_r3_unique_record: assert property (@(posedge clk) disable iff (!rst_n)
        mark_vld_i |-> $onehot0(mk_hit));

    // R6: overflow is always also a conflict
    a_r6_overflow_is_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> conflict_o);

    // R7: exception forces the conflict
    a_r7_exception: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_i && !restart_i) |=> conflict_o);

    // R8: sticky until restart
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict_o && !restart_i) |=> conflict_o);

    // R8: restart wipes records and flags
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!conflict_o && !overflow_o && (st_q.vld == '0)));

    // R9: violate lasts a single cycle
    a_r9_violate_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        violate_o |=> !violate_o);

    // R4: a live record never carries a zero count
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cnt_chk
        a_r4_live_count: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.vld[g] |-> (st_q.cnt[g] != '0));
    end

endmodule

// File: tb/slcb_buffer_bench.sv
module slcb_buffer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart_i = 1'b0;
    logic        mark_vld_i = 1'b0;
    logic [31:0] mark_addr_i = '0;
    logic        unmark_vld_i = 1'b0;
    logic [31:0] unmark_addr_i = '0;
    logic        store_vld_i = 1'b0;
    logic [31:0] store_addr_i = '0;
    logic        exc_i = 1'b0;
    logic        conflict_o, overflow_o, violate_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  c;
        logic  o;
        logic  v;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    localparam logic [31:0] A = 32'h0000_1000;
    localparam logic [31:0] B = 32'h0000_2000;
    localparam logic [31:0] D = 32'h0000_9000;

    always #10 clk = ~clk;

    slcb_buffer u_slcb_buffer (
        .clk(clk), .rst_n(rst_n), .restart_i(restart_i),
        .mark_vld_i(mark_vld_i), .mark_addr_i(mark_addr_i),
        .unmark_vld_i(unmark_vld_i), .unmark_addr_i(unmark_addr_i),
        .store_vld_i(store_vld_i), .store_addr_i(store_addr_i),
        .exc_i(exc_i), .conflict_o(conflict_o), .overflow_o(overflow_o),
        .violate_o(violate_o)
    );

    task automatic check3(input logic c, input logic o, input logic v, input string tag);
        checks++;
        if (conflict_o !== c || overflow_o !== o || violate_o !== v) begin
            errors++;
            $display("FAIL %s: actual c/o/v=%b%b%b expected %b%b%b",
                     tag, conflict_o, overflow_o, violate_o, c, o, v);
        end
    endtask

    // Driver: apply one cycle of inputs and queue the outputs due after the next edge.
    task automatic cyc(input logic mk, input logic [31:0] ma,
                       input logic um, input logic [31:0] ua,
                       input logic sv, input logic [31:0] sa,
                       input logic ex, input logic rs,
                       input logic ec, input logic eo, input logic ev,
                       input string tag);
        exp_t e;
        mark_vld_i = mk;   mark_addr_i = ma;
        unmark_vld_i = um; unmark_addr_i = ua;
        store_vld_i = sv;  store_addr_i = sa;
        exc_i = ex;        restart_i = rs;
        e.c = ec; e.o = eo; e.v = ev; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare a quarter period after each rising edge.
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check3(e.c, e.o, e.v, e.tag);
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check3(1'b0, 1'b0, 1'b0, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        //   mk ma    um ua   sv sa        ex rs   c o v
        cyc(1, A,    0, 0,   0, 0,        0, 0,   0, 0, 0, "R1 idle after mark");
        cyc(0, 0,    0, 0,   1, B,        0, 0,   0, 0, 0, "R3 store to unheld word");
        cyc(0, 0,    0, 0,   1, A + 3,    0, 0,   1, 0, 1, "R2 store hit with byte offset");
        cyc(0, 0,    0, 0,   1, A,        0, 0,   1, 0, 0, "R9 no second pulse");
        cyc(0, 0,    0, 0,   0, 0,        0, 0,   1, 0, 0, "R8 sticky conflict");
        cyc(0, 0,    0, 0,   0, 0,        0, 1,   0, 0, 0, "R8 restart clears flags");
        cyc(0, 0,    0, 0,   1, A,        0, 0,   0, 0, 0, "R8 restart cleared records");

        cyc(1, A,    0, 0,   0, 0,        0, 0,   0, 0, 0, "R4 mark 1");
        cyc(1, A,    0, 0,   0, 0,        0, 0,   0, 0, 0, "R4 mark 2");
        cyc(0, 0,    1, A,   0, 0,        0, 0,   0, 0, 0, "R4 unmark 1");
        cyc(0, 0,    1, A,   0, 0,        0, 0,   0, 0, 0, "R4 unmark 2");
        cyc(0, 0,    0, 0,   1, A,        0, 0,   0, 0, 0, "R4 record released at zero");
        cyc(1, A,    0, 0,   0, 0,        0, 0,   0, 0, 0, "R4 mark 1 again");
        cyc(1, A,    0, 0,   0, 0,        0, 0,   0, 0, 0, "R4 mark 2 again");
        cyc(0, 0,    1, A,   0, 0,        0, 0,   0, 0, 0, "R4 unmark once");
        cyc(0, 0,    1, B,   0, 0,        0, 0,   0, 0, 0, "R4 unmark of unheld ignored");
        cyc(0, 0,    0, 0,   1, A,        0, 0,   1, 0, 1, "R4 count keeps record live");
        cyc(0, 0,    0, 0,   0, 0,        0, 1,   0, 0, 0, "R8 restart");

        cyc(1, A,    0, 0,   1, A,        0, 0,   0, 0, 0, "R5 same-cycle mark not seen");
        cyc(0, 0,    1, A,   1, A,        0, 0,   1, 0, 1, "R5 same-cycle unmark not yet applied");
        cyc(0, 0,    0, 0,   0, 0,        0, 1,   0, 0, 0, "R8 restart");

        cyc(1, A,    0, 0,   0, 0,        0, 0,   0, 0, 0, "R3 first mark");
        cyc(1, A,    0, 0,   0, 0,        0, 0,   0, 0, 0, "R3 duplicate mark shares record");
        for (int k = 1; k <= 7; k++)
            cyc(1, 32'h4000 + k * 16, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 fill remaining records");
        cyc(1, D,    1, 32'h4010, 0, 0,   0, 0,   1, 1, 1, "R6 overflow when full");
        cyc(0, 0,    0, 0,   0, 0,        0, 0,   1, 1, 0, "R6 overflow sticky");
        cyc(0, 0,    0, 0,   0, 0,        0, 1,   0, 0, 0, "R8 restart clears overflow");

        for (int k = 0; k < 7; k++)
            cyc(1, B, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 count up to maximum");
        cyc(1, B,    0, 0,   0, 0,        0, 0,   1, 1, 1, "R6 count saturation overflow");
        cyc(0, 0,    0, 0,   0, 0,        0, 1,   0, 0, 0, "R8 restart");

        cyc(0, 0,    0, 0,   0, 0,        1, 0,   1, 0, 1, "R7 exception forces conflict");
        cyc(0, 0,    0, 0,   0, 0,        0, 0,   1, 0, 0, "R7 conflict held");
        cyc(1, A,    0, 0,   0, 0,        1, 1,   0, 0, 0, "R8 restart beats exception");
        cyc(0, 0,    0, 0,   1, A,        0, 0,   0, 0, 0, "R8 restart beats mark");
        cyc(0, 0,    0, 0,   0, 0,        0, 0,   0, 0, 0, "R1 quiet");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule